// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host side of a two-wire debug link. On a start pulse it runs one complete read or write access over a clock line and a bidirectional data line. It sends an 8-bit request header, releases the data line for a turnaround gap, and captures a 3-bit acknowledge. If the acknowledge is OK, it moves a 32-bit word plus parity in the requested direction. It can then drive a programmable run of low idle clocks. When a write is rejected and the dummy-phase option is on, it still clocks out a word of zeros with a zero parity bit, so that the line protocol stays in step.

All settings are captured at the start pulse: the request nibble, the write word, the turnaround length, the idle count, the dummy-phase option and the clock divider. The data line is controlled through an output-enable, an output value and a sampled input. The host changes the line while the debug clock falls and samples it when the clock rises. At the end a one-cycle done pulse appears, and the acknowledge, read word and parity-error flag stay unchanged until the next start.

Top module: `swd_xfer_engine`

## Requirements
- R1: The request header is 8 bits sent LSB first, in this order: 1, req[0] (port select), req[1] (1 = read), req[2], req[3], even parity of req[3:0], 0, 1.
- R2: After the header the host releases the line (swdio_oe = 0) for trn_sel+1 clocks and then for 3 acknowledge clocks. The turnaround samples are discarded, and ack[0] holds the first acknowledge bit received.
- R3: An acknowledge of 3'b001 is OK and enables the data phase. Any other value skips it.
- R4: On an OK read the host samples 32 data bits LSB first into rdata and then one parity bit. par_err is 1 exactly when the received parity bit differs from the even parity of rdata.
- R5: After the read parity bit the host keeps the line released for trn_sel+1 clocks before it drives the line again.
- R6: On an OK write the host releases the line for trn_sel+1 clocks, then drives wdata LSB first and then the even parity of wdata.
- R7: After an OK data phase the host drives the line low for idle_cnt clocks. A count of zero adds none. After a rejected access no idle clocks are sent.
- R8: After a rejected acknowledge the host releases the line for trn_sel+1 clocks. For a write with dummy_en = 1 it then drives 33 zero bits. For any other rejected access the transaction ends there.
- R9: Each swclk half period lasts div+1 clk cycles. done goes high 2*(div+1)*N clk cycles after the edge that samples start, where N is the number of swclk periods in the transaction.
- R10: swclk is low whenever no transaction runs, and the line is then driven low (swdio_oe = 1, swdio_out = 0). swdio_oe and swdio_out never change while swclk is high.
- R11: done is a single-cycle pulse. ack, rdata and par_err keep their values from the end of a transaction until the next accepted start. A start during a transaction is ignored.
- R12: rdata reads zero after any transaction that had no read data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a transaction when idle |
| req | input | 4 | Request nibble: [0] port select, [1] read, [3:2] register address |
| wdata | input | 32 | Word to write |
| trn_sel | input | 2 | Turnaround length minus one |
| idle_cnt | input | IDLE_W | Low idle clocks after an OK transfer |
| dummy_en | input | 1 | Send a zero data phase after a rejected write |
| div | input | DIV_W | Half-period length minus one, in clk cycles |
| swclk | output | 1 | Debug clock |
| swdio_out | output | 1 | Data line drive value |
| swdio_oe | output | 1 | Data line drive enable |
| swdio_in | input | 1 | Data line sampled value |
| done | output | 1 | End-of-transaction pulse |
| ack | output | 3 | Received acknowledge |
| rdata | output | 32 | Received read word |
| par_err | output | 1 | Read parity mismatch |

## Verification
A small target model answers on the data line and records what the host drives at every rising swclk edge. Reads are tried with matching and deliberately corrupted parity. Writes are tried with dense and sparse words, so a bit-order or parity fault shows up in the recorded stream. WAIT and FAULT acknowledges are tried with and without the dummy option, so the skipped data phase can be told apart from the zero-filled one. Turnaround lengths from one to four and dividers from 0 to 3 are covered, so a mis-sized acknowledge window or a wrong half period changes the acknowledge, the clock count or the elapsed cycles.

// File: rtl/swd_pkg.sv
// Shared constants and the phase encoding of the debug-link host.
// Assumes a fixed 32-bit data word, as the link protocol defines it.
package swd_pkg;
    localparam int WORD_W  = 32;
    localparam int FRAME_W = WORD_W + 1;   // data word plus parity bit
    localparam int HDR_W   = 8;
    localparam logic [2:0] ACK_OK = 3'b001;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_TRNACK,
        PH_RDATA,
        PH_TRN2,
        PH_WDATA,
        PH_TAIL
    } phase_e;
endpackage

// File: rtl/swd_clk_gen.sv
// Debug clock generator. While run is high it toggles swclk every div+1
// clk cycles and flags the cycle in which the clock is about to rise or fall.
// Assumes div is held constant while run is high.
module swd_clk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             swclk,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt_q;
    logic             swclk_q;
    logic             edge_now;

    // Half period complete in this cycle
    assign edge_now = run && (cnt_q == div);
    assign rise     = edge_now && !swclk_q;
    assign fall     = edge_now && swclk_q;
    assign swclk    = swclk_q;

    // Half-period counter and clock toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            swclk_q <= 1'b0;
        end else if (!run) begin
            cnt_q   <= '0;
            swclk_q <= 1'b0;
        end else if (edge_now) begin
            cnt_q   <= '0;
            swclk_q <= ~swclk_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // R9
    half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= div));
    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !swclk_q);
endmodule

// File: rtl/swd_hdr_pack.sv
// Builds the 8-bit request header (bit 0 goes out first) from the request nibble.
// Purely combinational.
module swd_hdr_pack (
    input  logic [3:0] req,
    output logic [7:0] hdr
);
    // Start, nibble, even parity, stop, park
    assign hdr = {1'b1, 1'b0, ^req, req, 1'b1};
endmodule

// File: rtl/swd_seq.sv
// Transaction sequencer. Walks header, turnaround+acknowledge, data,
// second turnaround and idle tail, one bit per swclk period. Drives the
// line from registered state, so changes occur only at falling swclk
// edges. Samples on the rise tick. Assumes rise and fall never coincide.
module swd_seq
    import swd_pkg::*;
#(
    parameter int IDLE_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        req,
    input  logic [WORD_W-1:0] wdata,
    input  logic [1:0]        trn_sel,
    input  logic [IDLE_W-1:0] idle_cnt,
    input  logic              dummy_en,
    input  logic [DIV_W-1:0]  div,
    input  logic              swdio_in,
    input  logic              rise,
    input  logic              fall,
    output logic              run,
    output logic [DIV_W-1:0]  div_q,
    output logic              swdio_out,
    output logic              swdio_oe,
    output logic              done,
    output logic [2:0]        ack,
    output logic [WORD_W-1:0] rdata,
    output logic              par_err
);
    localparam int CNT_W = (IDLE_W > 6) ? IDLE_W : 6;
    localparam logic [CNT_W-1:0] LAST_HDR  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(FRAME_W - 1);

    phase_e             phase_q;
    logic [CNT_W-1:0]   bcnt_q;
    logic [3:0]         req_q;
    logic [WORD_W-1:0]  wdata_q;
    logic [2:0]         trn_q;
    logic [IDLE_W-1:0]  idle_q;
    logic               dph_q;
    logic [2:0]         ack_sr_q;
    logic [FRAME_W-1:0] rxsr_q;
    logic [FRAME_W-1:0] txsr_q;
    logic               ok_q;
    logic               done_q;
    logic [2:0]         ack_q;
    logic [WORD_W-1:0]  rdata_q;
    logic               par_q;
    logic [7:0]         hdr;
    logic               is_read;
    logic               ack_ok_now;
    logic [CNT_W-1:0]   trn_last;
    logic [CNT_W-1:0]   trnack_last;
    logic [CNT_W-1:0]   tail_last;

    swd_hdr_pack u_hdr (
        .req (req_q),
        .hdr (hdr)
    );

    // Derived bit-count limits for the current transaction
    assign is_read     = req_q[1];
    assign ack_ok_now  = (ack_sr_q == ACK_OK);
    assign trn_last    = CNT_W'(trn_q) - CNT_W'(1);
    assign trnack_last = CNT_W'(trn_q) + CNT_W'(2);
    assign tail_last   = CNT_W'(idle_q) - CNT_W'(1);

    // Line drive from the current phase
    always_comb begin
        swdio_oe  = 1'b0;
        swdio_out = 1'b0;
        case (phase_q)
            PH_IDLE, PH_TAIL: swdio_oe = 1'b1;
            PH_HDR: begin
                swdio_oe  = 1'b1;
                swdio_out = hdr[bcnt_q[2:0]];
            end
            PH_WDATA: begin
                swdio_oe  = 1'b1;
                swdio_out = txsr_q[0];
            end
            default: ;
        endcase
    end

    assign run     = (phase_q != PH_IDLE);
    assign done    = done_q;
    assign ack     = ack_q;
    assign rdata   = rdata_q;
    assign par_err = par_q;

    // Phase sequencing, sampling and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            bcnt_q   <= '0;
            req_q    <= '0;
            wdata_q  <= '0;
            trn_q    <= 3'd1;
            idle_q   <= '0;
            dph_q    <= 1'b0;
            div_q    <= '0;
            ack_sr_q <= '0;
            rxsr_q   <= '0;
            txsr_q   <= '0;
            ok_q     <= 1'b0;
            done_q   <= 1'b0;
            ack_q    <= '0;
            rdata_q  <= '0;
            par_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (phase_q == PH_IDLE) begin
                if (start) begin
                    phase_q  <= PH_HDR;
                    bcnt_q   <= '0;
                    req_q    <= req;
                    wdata_q  <= wdata;
                    trn_q    <= {1'b0, trn_sel} + 3'd1;
                    idle_q   <= idle_cnt;
                    dph_q    <= dummy_en;
                    div_q    <= div;
                    ack_sr_q <= '0;
                    ok_q     <= 1'b0;
                    ack_q    <= '0;
                    rdata_q  <= '0;
                    par_q    <= 1'b0;
                end
            end else begin
                if (rise) begin
                    if (phase_q == PH_TRNACK)
                        ack_sr_q <= {swdio_in, ack_sr_q[2:1]};
                    if (phase_q == PH_RDATA)
                        rxsr_q <= {swdio_in, rxsr_q[FRAME_W-1:1]};
                end
                if (fall) begin
                    bcnt_q <= bcnt_q + 1'b1;
                    case (phase_q)
                        PH_HDR: begin
                            if (bcnt_q == LAST_HDR) begin
                                phase_q <= PH_TRNACK;
                                bcnt_q  <= '0;
                            end
                        end
                        PH_TRNACK: begin
                            if (bcnt_q == trnack_last) begin
                                bcnt_q <= '0;
                                ack_q  <= ack_sr_q;
                                ok_q   <= ack_ok_now;
                                txsr_q <= ack_ok_now ? {^wdata_q, wdata_q} : '0;
                                phase_q <= (ack_ok_now && is_read) ? PH_RDATA : PH_TRN2;
                            end
                        end
                        PH_RDATA: begin
                            if (bcnt_q == LAST_WORD) begin
                                bcnt_q  <= '0;
                                rdata_q <= rxsr_q[WORD_W-1:0];
                                par_q   <= ^rxsr_q;
                                phase_q <= PH_TRN2;
                            end
                        end
                        PH_TRN2: begin
                            if (bcnt_q == trn_last) begin
                                bcnt_q <= '0;
                                if (ok_q && is_read) begin
                                    if (idle_q == '0) begin
                                        phase_q <= PH_IDLE;
                                        done_q  <= 1'b1;
                                    end else begin
                                        phase_q <= PH_TAIL;
                                    end
                                end else if (!is_read && (ok_q || dph_q)) begin
                                    phase_q <= PH_WDATA;
                                end else begin
                                    phase_q <= PH_IDLE;
                                    done_q  <= 1'b1;
                                end
                            end
                        end
                        PH_WDATA: begin
                            txsr_q <= {1'b0, txsr_q[FRAME_W-1:1]};
                            if (bcnt_q == LAST_WORD) begin
                                bcnt_q <= '0;
                                if (ok_q && (idle_q != '0)) begin
                                    phase_q <= PH_TAIL;
                                end else begin
                                    phase_q <= PH_IDLE;
                                    done_q  <= 1'b1;
                                end
                            end
                        end
                        PH_TAIL: begin
                            if (bcnt_q == tail_last) begin
                                phase_q <= PH_IDLE;
                                done_q  <= 1'b1;
                            end
                        end
                        default: phase_q <= PH_IDLE;
                    endcase
                end
            end
        end
    end

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase_q) == PH_IDLE && phase_q == PH_IDLE)
            |-> ($stable(ack_q) && $stable(rdata_q) && $stable(par_q)));
    // R8
    dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_WDATA && !ok_q) |-> !swdio_out);
    // R4
    par_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_q |-> (is_read && ok_q));
    // R3
    data_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RDATA) |-> (ack_q == ACK_OK));
endmodule

// File: rtl/swd_xfer_engine.sv
// Top of the debug-link host transaction engine. Joins the sequencer
// to the clock generator. Assumes swdio_in is already synchronised
// to clk by the pad logic.
module swd_xfer_engine
    import swd_pkg::*;
#(
    parameter int IDLE_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        req,
    input  logic [WORD_W-1:0] wdata,
    input  logic [1:0]        trn_sel,
    input  logic [IDLE_W-1:0] idle_cnt,
    input  logic              dummy_en,
    input  logic [DIV_W-1:0]  div,
    output logic              swclk,
    output logic              swdio_out,
    output logic              swdio_oe,
    input  logic              swdio_in,
    output logic              done,
    output logic [2:0]        ack,
    output logic [WORD_W-1:0] rdata,
    output logic              par_err
);
    logic             run;
    logic             rise;
    logic             fall;
    logic [DIV_W-1:0] div_q;

    swd_seq #(.IDLE_W(IDLE_W), .DIV_W(DIV_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req       (req),
        .wdata     (wdata),
        .trn_sel   (trn_sel),
        .idle_cnt  (idle_cnt),
        .dummy_en  (dummy_en),
        .div       (div),
        .swdio_in  (swdio_in),
        .rise      (rise),
        .fall      (fall),
        .run       (run),
        .div_q     (div_q),
        .swdio_out (swdio_out),
        .swdio_oe  (swdio_oe),
        .done      (done),
        .ack       (ack),
        .rdata     (rdata),
        .par_err   (par_err)
    );

    swd_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div_q),
        .swclk (swclk),
        .rise  (rise),
        .fall  (fall)
    );

    // R10
    line_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swclk && $past(swclk)) |-> ($stable(swdio_oe) && $stable(swdio_out)));
endmodule

// File: tb/swd_xfer_engine_test.sv
`timescale 1ns/1ps
module swd_xfer_engine_test;
    typedef struct packed {
        logic [3:0]  req;
        logic [31:0] wd;
        logic [1:0]  trn;
        logic [7:0]  idle;
        logic        dph;
        logic [7:0]  div;
        logic [2:0]  ackr;
        logic [31:0] rd;
        logic        flip;
    } vec_t;

    localparam int NV = 9;
    // req: [0] port select, [1] read, [3:2] address
    localparam vec_t VECS [NV] = '{
        '{4'b0010, 32'h0,         2'd0, 8'd0,  1'b0, 8'd0, 3'b001, 32'hA5A5_0F0F, 1'b0},
        '{4'b1111, 32'h0,         2'd1, 8'd3,  1'b0, 8'd1, 3'b001, 32'h8000_0001, 1'b1},
        '{4'b0100, 32'hDEAD_BEEF, 2'd0, 8'd2,  1'b0, 8'd0, 3'b001, 32'h0,         1'b0},
        '{4'b1001, 32'h0000_0007, 2'd3, 8'd0,  1'b0, 8'd2, 3'b001, 32'h0,         1'b0},
        '{4'b0101, 32'h1234_5678, 2'd0, 8'd5,  1'b1, 8'd0, 3'b010, 32'h0,         1'b0},
        '{4'b1000, 32'hFFFF_0000, 2'd1, 8'd2,  1'b0, 8'd0, 3'b100, 32'h0,         1'b0},
        '{4'b0011, 32'h0,         2'd0, 8'd4,  1'b1, 8'd0, 3'b010, 32'h1111_2222, 1'b0},
        '{4'b0110, 32'h0,         2'd2, 8'd40, 1'b0, 8'd0, 3'b001, 32'hFFFF_FFFF, 1'b0},
        '{4'b1100, 32'h0000_0001, 2'd0, 8'd1,  1'b0, 8'd3, 3'b001, 32'h0,         1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  req = '0;
    logic [31:0] wdata = '0;
    logic [1:0]  trn_sel = '0;
    logic [7:0]  idle_cnt = '0;
    logic        dummy_en = 1'b0;
    logic [7:0]  div = '0;
    logic        swclk, swdio_out, swdio_oe, done, par_err;
    logic        swdio_in = 1'b0;
    logic [2:0]  ack;
    logic [31:0] rdata;

    int checks = 0;
    int fails  = 0;
    int nb     = 0;
    int nexp   = 0;
    logic exp_oe  [256];
    logic exp_out [256];
    logic resp    [256];
    logic got_oe  [256];
    logic got_out [256];

    swd_xfer_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .req(req), .wdata(wdata),
        .trn_sel(trn_sel), .idle_cnt(idle_cnt), .dummy_en(dummy_en), .div(div),
        .swclk(swclk), .swdio_out(swdio_out), .swdio_oe(swdio_oe),
        .swdio_in(swdio_in), .done(done), .ack(ack), .rdata(rdata), .par_err(par_err)
    );

    always #10 clk = ~clk;

    // Target model: record host drive at each rise, present the next reply bit at each fall
    always @(posedge swclk) begin
        if (nb < 256) begin
            got_oe[nb]  = swdio_oe;
            got_out[nb] = swdio_out;
        end
        nb = nb + 1;
    end
    always @(negedge swclk) begin
        if (nb < 256) swdio_in = resp[nb];
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic oe, input logic o, input logic r);
        exp_oe[nexp]  = oe;
        exp_out[nexp] = o;
        resp[nexp]    = r;
        nexp++;
    endtask

    task automatic run_vec(input vec_t v, input int glitch_at);
        int t;
        bit ok, rd;
        logic [7:0] hdr;
        int cyc;
        int mis_hdr, mis_rest;
        logic [2:0] a0;
        logic [31:0] r0;
        logic p0;
        t   = int'(v.trn) + 1;
        ok  = (v.ackr == 3'b001);
        rd  = v.req[1];
        hdr = {1'b1, 1'b0, ^v.req, v.req, 1'b1};
        for (int i = 0; i < 256; i++) begin
            exp_oe[i] = 1'b0; exp_out[i] = 1'b0; resp[i] = 1'b0;
        end
        nexp = 0;
        for (int i = 0; i < 8; i++) push(1'b1, hdr[i], 1'b0);
        for (int i = 0; i < t; i++) push(1'b0, 1'b0, (i % 2 == 0));
        for (int i = 0; i < 3; i++) push(1'b0, 1'b0, v.ackr[i]);
        if (ok && rd) begin
            for (int i = 0; i < 32; i++) push(1'b0, 1'b0, v.rd[i]);
            push(1'b0, 1'b0, (^v.rd) ^ v.flip);
            for (int i = 0; i < t; i++) push(1'b0, 1'b0, 1'b1);
            for (int i = 0; i < int'(v.idle); i++) push(1'b1, 1'b0, 1'b1);
        end else if (ok) begin
            for (int i = 0; i < t; i++) push(1'b0, 1'b0, 1'b1);
            for (int i = 0; i < 32; i++) push(1'b1, v.wd[i], 1'b0);
            push(1'b1, ^v.wd, 1'b0);
            for (int i = 0; i < int'(v.idle); i++) push(1'b1, 1'b0, 1'b1);
        end else begin
            for (int i = 0; i < t; i++) push(1'b0, 1'b0, 1'b1);
            if (!rd && v.dph)
                for (int i = 0; i < 33; i++) push(1'b1, 1'b0, 1'b1);
        end

        @(negedge clk);
        req = v.req; wdata = v.wd; trn_sel = v.trn; idle_cnt = v.idle;
        dummy_en = v.dph; div = v.div;
        nb = 0;
        swdio_in = resp[0];
        start = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) start = 1'b0;
            if (glitch_at > 0 && cyc == glitch_at) begin
                start = 1'b1; req = ~v.req; trn_sel = ~v.trn; div = 8'hFF; wdata = ~v.wd;
            end
            if (glitch_at > 0 && cyc == glitch_at + 1) start = 1'b0;
        end while (!done && cyc < 5000);

        // R9: done seen at the negedge after 2*(div+1)*N edges
        chk(cyc == 2 * (int'(v.div) + 1) * nexp + 1, "R9 cycles", 64'(cyc), 64'(2 * (int'(v.div) + 1) * nexp + 1));
        chk(ack == v.ackr, "R2/R3 ack", 64'(ack), 64'(v.ackr));
        chk(rdata == ((ok && rd) ? v.rd : 32'h0), "R4/R12 rdata", 64'(rdata), 64'((ok && rd) ? v.rd : 32'h0));
        chk(par_err == (ok && rd && v.flip), "R4 par_err", 64'(par_err), 64'(ok && rd && v.flip));
        chk(nb == nexp, "R7/R8 bit count", 64'(nb), 64'(nexp));
        mis_hdr = 0; mis_rest = 0;
        for (int i = 0; i < nexp && i < 256; i++) begin
            if (got_oe[i] !== exp_oe[i] || (exp_oe[i] && got_out[i] !== exp_out[i])) begin
                if (i < 8) mis_hdr++; else mis_rest++;
            end
        end
        chk(mis_hdr == 0, "R1 header", 64'(mis_hdr), 64'd0);
        if (ok && rd)      chk(mis_rest == 0, "R5 read stream", 64'(mis_rest), 64'd0);
        else if (ok)       chk(mis_rest == 0, "R6 write stream", 64'(mis_rest), 64'd0);
        else               chk(mis_rest == 0, "R8 reject stream", 64'(mis_rest), 64'd0);
        a0 = ack; r0 = rdata; p0 = par_err;
        @(negedge clk);
        chk(done == 1'b0, "R11 done pulse", 64'(done), 64'd0);
        repeat (5) @(negedge clk);
        chk(ack == a0 && rdata == r0 && par_err == p0 && !swclk, "R11 hold", {29'd0, ack, rdata, par_err, swclk}, {29'd0, a0, r0, p0, 1'b0});
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset and idle state
        chk(swclk == 1'b0, "R10 swclk idle", 64'(swclk), 64'd0);
        chk(swdio_oe == 1'b1 && swdio_out == 1'b0, "R10 line idle", {swdio_oe, swdio_out}, 64'h2);
        chk(done == 1'b0, "R11 done reset", 64'(done), 64'd0);
        chk(ack == 3'd0 && par_err == 1'b0, "R11 result reset", {ack, par_err}, 64'd0);
        chk(rdata == 32'd0, "R12 rdata reset", 64'(rdata), 64'd0);

        for (int k = 0; k < NV; k++) run_vec(VECS[k], 0);

        // R11: a start during a transaction is ignored
        run_vec(VECS[0], 6);
        run_vec(VECS[2], 30);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule